// File: doc/BRIEF.md
# Dual-Channel Averaging Offset Calibration Engine

This block estimates and cancels a constant DC error on each of two 10-bit sample streams. A rising edge on the calibration request opens a window of fixed length, measured in clock cycles. The first cycles of the window are thrown away so that samples still in flight from before the request do not count. The samples of the remaining cycles, taken while the analog side holds the inputs at zero difference, are summed separately for each channel. When the window closes, each sum is divided by the sample count with rounding, and the result is stored as a signed distance from mid-scale.

Every sample that arrives after the window is corrected by subtracting that stored distance, and the result is clamped to the legal code range. Until the first calibration the stored distance is zero, so data passes through unchanged. While a window is running, the previous correction stays in force and data keeps flowing, so a system can recalibrate without stopping the stream. One register stage sits between each raw input and its corrected output.

Top module: `offset_cal_engine`

## Requirements
- R1: A window starts only at a clock edge where `cal_req` is 1 and was 0 at the previous edge. If `cal_req` is held high, no further window starts. `busy` goes high in the cycle right after the starting edge.
- R2: `busy` stays high for exactly 34 consecutive cycles and then returns low.
- R3: The samples presented during the first 2 cycles of the window are not summed. The samples presented during cycles 3 to 34 are summed, 32 per channel.
- R4: When the window ends, each channel stores offset = round(sum/32) − 512, with halves rounded up. This is computed as (sum + 16) >> 5. The corrected value is raw − offset.
- R5: Each channel has its own sum and its own stored offset. Channel 0 occupies bits [9:0] of the data buses and channel 1 occupies bits [19:10].
- R6: The corrected value is clamped: results below 0 give 0, and results above 1023 give 1023. There is no wrap-around.
- R7: A rising edge on `cal_req` while `busy` is high is ignored. It neither lengthens the current window nor queues a new one.
- R8: During a window, outputs use the offset from before the window. This includes the sample of the last busy cycle. The new offset applies from the first sample presented after `busy` falls.
- R9: After reset, `busy` is 0, `out_valid` is 0, `out_data` is 0, and both offsets are zero, so data passes through unchanged.
- R10: `out_valid[i]` and the corrected sample of channel i appear one cycle after `in_valid[i]` and the raw sample are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample per channel per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_req | input | 1 | Calibration request; its rising edge starts a window |
| in_valid | input | 2 | Per-channel raw sample valid |
| in_data | input | 20 | Raw samples, channel 0 in [9:0], channel 1 in [19:10] |
| out_valid | output | 2 | Per-channel corrected sample valid |
| out_data | output | 20 | Corrected samples, same packing as `in_data` |
| busy | output | 1 | High for the whole calibration window |

## Verification
The first window feeds channel 0 a constant value and channel 1 a value that alternates between two codes. The alternating sum lands exactly on a half, so the stored offset shows whether the design rounds or truncates. Different offsets on the two channels also show whether the channels are kept separate. The two discarded cycles carry a large value, which would visibly shift the averages if they were summed by mistake. Further patterns test exact and overdriven values at both clamp limits, a request held high across the end of a window, and a second rising edge inside a window. Outputs sampled inside the window and in the first cycle after it separate old-offset use from new-offset use.

// File: rtl/ocal_pkg.sv
package ocal_pkg;

   // Phases of the calibration window
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FLUSH = 2'd1,
      PH_ACCUM = 2'd2
   } ocal_phase_e;

endpackage

// File: rtl/ocal_sequencer.sv
module ocal_sequencer #(
   parameter int WIN_LEN  = 34,
   parameter int SKIP_LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cal_req,
   output logic busy,
   output logic take,
   output logic last
);
   import ocal_pkg::*;

   localparam int CNT_W = $clog2(WIN_LEN);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_LEN - 1);
   localparam logic [CNT_W-1:0] SKIP_IDX = CNT_W'(SKIP_LEN - 1);

   ocal_phase_e      phase;
   logic [CNT_W-1:0] cnt;
   logic             req_q;
   logic             req_edge;

   assign req_edge = cal_req & ~req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= cal_req;
         case (phase)
            PH_IDLE: begin
               if (req_edge) begin
                  phase <= PH_FLUSH;
                  cnt   <= '0;
               end
            end
            PH_FLUSH: begin
               cnt <= cnt + 1'b1;
               if (cnt == SKIP_IDX) phase <= PH_ACCUM;
            end
            PH_ACCUM: begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST_IDX) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy = (phase != PH_IDLE);
   assign take = (phase == PH_ACCUM);
   assign last = (phase == PH_ACCUM) && (cnt == LAST_IDX);

endmodule

// File: rtl/ocal_accum.sv
module ocal_accum #(
   parameter int DATA_W        = 10,
   parameter int AVG_LOG2      = 5,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              take,
   input  logic              last,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W:0]   offset
);
   localparam int SUM_W = DATA_W + AVG_LOG2;
   localparam logic [SUM_W:0]  HALF = (SUM_W+1)'(1) << (AVG_LOG2 - 1);
   localparam logic [DATA_W:0] MID  = (DATA_W+1)'(1) << (DATA_W - 1);

   logic [SUM_W-1:0]  acc;
   logic [SUM_W-1:0]  sum_next;
   logic [DATA_W:0]   quot;
   logic [DATA_W-1:0] avg;

   assign sum_next = acc + ((take && in_valid) ? SUM_W'(raw) : '0);

   generate
      if (ROUND_NEAREST) begin : g_round
         logic [SUM_W:0] rnd;
         assign rnd  = {1'b0, sum_next} + HALF;
         assign quot = (DATA_W+1)'(rnd >> AVG_LOG2);
      end else begin : g_trunc
         assign quot = (DATA_W+1)'(sum_next >> AVG_LOG2);
      end
   endgenerate

   // Clamp a rounding carry out of range
   assign avg = quot[DATA_W] ? '1 : quot[DATA_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc    <= '0;
         offset <= '0;
      end else begin
         if (!busy)
            acc <= '0;
         else if (take)
            acc <= sum_next;
         if (last)
            offset <= {1'b0, avg} - MID;
      end
   end

endmodule

// File: rtl/ocal_corrector.sv
module ocal_corrector #(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] raw,
   input  logic [DATA_W:0]   offset,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam logic signed [DATA_W+1:0] MAX_CODE =
      $signed((DATA_W+2)'((1 << DATA_W) - 1));

   logic signed [DATA_W+1:0] diff;
   logic [DATA_W-1:0]        clipped;

   assign diff = $signed({2'b00, raw}) - $signed({offset[DATA_W], offset});

   always_comb begin
      if (diff < 0)
         clipped = '0;
      else if (diff > MAX_CODE)
         clipped = '1;
      else
         clipped = diff[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         out_data  <= clipped;
      end
   end

endmodule

// File: rtl/offset_cal_engine.sv
module offset_cal_engine #(
   parameter int NUM_CH        = 2,
   parameter int DATA_W        = 10,
   parameter int SKIP_LEN      = 2,
   parameter int AVG_LOG2      = 5,
   parameter int WIN_LEN       = 34,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cal_req,
   input  logic [NUM_CH-1:0]        in_valid,
   input  logic [NUM_CH*DATA_W-1:0] in_data,
   output logic [NUM_CH-1:0]        out_valid,
   output logic [NUM_CH*DATA_W-1:0] out_data,
   output logic                     busy
);
   localparam int OFF_W = DATA_W + 1;

   // Parameter consistency checks
   if (WIN_LEN != SKIP_LEN + (1 << AVG_LOG2)) begin : g_bad_window
      $error("window length must equal discard cycles plus averaged samples");
   end
   if (SKIP_LEN < 1) begin : g_bad_skip
      $error("at least one discard cycle is required");
   end
   if (AVG_LOG2 < 1) begin : g_bad_avg
      $error("averaging needs at least two samples");
   end
   if (NUM_CH < 1 || DATA_W < 2) begin : g_bad_shape
      $error("channel count or data width out of range");
   end

   logic                    take;
   logic                    last;
   logic [NUM_CH*OFF_W-1:0] chan_off;

   ocal_sequencer #(
      .WIN_LEN (WIN_LEN),
      .SKIP_LEN(SKIP_LEN)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .cal_req(cal_req),
      .busy   (busy),
      .take   (take),
      .last   (last)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      ocal_accum #(
         .DATA_W       (DATA_W),
         .AVG_LOG2     (AVG_LOG2),
         .ROUND_NEAREST(ROUND_NEAREST)
      ) u_acc (
         .clk     (clk),
         .rst_n   (rst_n),
         .busy    (busy),
         .take    (take),
         .last    (last),
         .in_valid(in_valid[ch]),
         .raw     (in_data[ch*DATA_W +: DATA_W]),
         .offset  (chan_off[ch*OFF_W +: OFF_W])
      );

      ocal_corrector #(
         .DATA_W(DATA_W)
      ) u_cor (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (in_valid[ch]),
         .raw      (in_data[ch*DATA_W +: DATA_W]),
         .offset   (chan_off[ch*OFF_W +: OFF_W]),
         .out_valid(out_valid[ch]),
         .out_data (out_data[ch*DATA_W +: DATA_W])
      );
   end

endmodule

// File: rtl/ocal_checker.sv
module ocal_checker #(
   parameter int NUM_CH  = 2,
   parameter int DATA_W  = 10,
   parameter int WIN_LEN = 34
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cal_req,
   input logic                         busy,
   input logic [NUM_CH-1:0]            in_valid,
   input logic [NUM_CH*DATA_W-1:0]     in_data,
   input logic [NUM_CH-1:0]            out_valid,
   input logic [NUM_CH*DATA_W-1:0]     out_data,
   input logic [NUM_CH*(DATA_W+1)-1:0] chan_off
);
   localparam int OFF_W = DATA_W + 1;
   localparam int LEN_W = $clog2(WIN_LEN + 1) + 1;
   localparam logic [LEN_W-1:0] WIN_L = LEN_W'(WIN_LEN);
   localparam logic signed [DATA_W+1:0] MAX_CODE =
      $signed((DATA_W+2)'((1 << DATA_W) - 1));

   logic             req_d;
   logic             busy_q;
   logic             armed;
   logic             cal_seen;
   logic [LEN_W-1:0] busy_len;
   logic [NUM_CH-1:0] vq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_d    <= 1'b0;
         busy_q   <= 1'b0;
         armed    <= 1'b0;
         cal_seen <= 1'b0;
         busy_len <= '0;
         vq       <= '0;
      end else begin
         req_d    <= cal_req;
         busy_q   <= busy;
         armed    <= 1'b1;
         cal_seen <= cal_seen | (busy_q & ~busy);
         busy_len <= busy ? busy_len + 1'b1 : '0;
         vq       <= in_valid;
      end
   end

   AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cal_req && !req_d) |=> busy);                               // R1
   AST_NO_LEVEL_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(cal_req && !req_d)) |=> !busy);                           // R1
   AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == WIN_L));                                 // R2
   AST_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len < WIN_L));                                         // R7
   AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (out_valid == vq));                                         // R10

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
      logic signed [DATA_W+1:0] d_q;
      logic [DATA_W-1:0]        raw_q;
      logic [DATA_W-1:0]        o_w;
      logic [OFF_W-1:0]         off_w;

      assign o_w   = out_data[ch*DATA_W +: DATA_W];
      assign off_w = chan_off[ch*OFF_W +: OFF_W];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            d_q   <= '0;
            raw_q <= '0;
         end else begin
            raw_q <= in_data[ch*DATA_W +: DATA_W];
            d_q   <= $signed({2'b00, in_data[ch*DATA_W +: DATA_W]})
                     - $signed({off_w[OFF_W-1], off_w});
         end
      end

      AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && vq[ch] && d_q < 0) |-> (o_w == '0));                    // R6
      AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && vq[ch] && d_q > MAX_CODE) |-> (o_w == '1));             // R6
      AST_PASS_BEFORE_CAL: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && vq[ch] && !cal_seen) |-> (o_w == raw_q));               // R9
   end

endmodule

bind offset_cal_engine ocal_checker #(
   .NUM_CH (NUM_CH),
   .DATA_W (DATA_W),
   .WIN_LEN(WIN_LEN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cal_req  (cal_req),
   .busy     (busy),
   .in_valid (in_valid),
   .in_data  (in_data),
   .out_valid(out_valid),
   .out_data (out_data),
   .chan_off (chan_off)
);

// File: tb/sim_offset_cal_engine.sv
`timescale 1ns/1ps
module sim_offset_cal_engine;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cal_req;
   logic [1:0]  in_valid;
   logic [19:0] in_data;
   logic [1:0]  out_valid;
   logic [19:0] out_data;
   logic        busy;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   offset_cal_engine u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .cal_req  (cal_req),
      .in_valid (in_valid),
      .in_data  (in_data),
      .out_valid(out_valid),
      .out_data (out_data),
      .busy     (busy)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input int v0, input int v1);
      in_data = {10'(v1), 10'(v0)};
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int ch0();
      return int'(out_data[9:0]);
   endfunction

   function automatic int ch1();
      return int'(out_data[19:10]);
   endfunction

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // R9: state right after reset
   task automatic t_reset();
      chk("R9 busy", int'(busy), 0);
      chk("R9 out_valid", int'(out_valid), 0);
      chk("R9 out_data", int'(out_data), 0);
   endtask

   // R9/R10: pass-through before any calibration, valid alignment
   task automatic t_passthrough();
      in_valid = 2'b11;
      drive(300, 700);
      step();
      chk("R9 pass ch0", ch0(), 300);
      chk("R9 pass ch1", ch1(), 700);
      chk("R10 valid both", int'(out_valid), 3);
      in_valid = 2'b01;
      step();
      chk("R10 valid ch0 only", int'(out_valid), 1);
      in_valid = 2'b11;
   endtask

   // R1-R5, R8: first window, constant vs alternating with exact half
   task automatic t_calibrate_a();
      cal_req = 1'b1;
      drive(1000, 1000);
      step();
      chk("R1 busy after edge", int'(busy), 1);
      for (int i = 0; i < 34; i++) begin
         if (i < 2) drive(1000, 1000);          // R3 discarded cycles
         else       drive(520, (i % 2) ? 503 : 500);
         step();
         if (i == 5)  chk("R8 old offset in window", ch0(), 520);
         if (i == 32) chk("R2 busy before end", int'(busy), 1);
         if (i == 33) chk("R2 busy low after 34", int'(busy), 0);
      end
      drive(600, 600);
      step();
      chk("R1 level held no restart", int'(busy), 0);
      chk("R4 R3 ch0 corrected", ch0(), 592);
      chk("R4 R5 ch1 rounded", ch1(), 610);
      cal_req = 1'b0;
   endtask

   // R6: clamp at both ends, exact limits and overdrive
   task automatic t_saturate();
      drive(3, 1020);
      step();
      chk("R6 low clamp ch0", ch0(), 0);
      chk("R6 high clamp ch1", ch1(), 1023);
      drive(8, 1013);
      step();
      chk("R6 exact zero ch0", ch0(), 0);
      chk("R6 exact max ch1", ch1(), 1023);
      drive(1023, 0);
      step();
      chk("R6 in-range ch0", ch0(), 1015);
      chk("R6 in-range ch1", ch1(), 10);
   endtask

   // R7/R8: second edge inside window, old offset used to the last busy cycle
   task automatic t_busy_restart();
      cal_req = 1'b1;
      drive(512, 512);
      step();
      chk("R1 second start", int'(busy), 1);
      for (int i = 0; i < 34; i++) begin
         if (i == 4) cal_req = 1'b0;
         if (i == 5) cal_req = 1'b1;
         step();
         if (i == 10) chk("R8 ch0 old offset", ch0(), 504);
         if (i == 10) chk("R8 ch1 old offset", ch1(), 522);
         if (i == 32) chk("R7 busy not cut", int'(busy), 1);
         if (i == 33) begin
            chk("R7 busy not extended", int'(busy), 0);
            chk("R8 last busy sample old", ch0(), 504);
         end
      end
      drive(700, 700);
      step();
      chk("R8 new offset ch0", ch0(), 700);
      chk("R8 new offset ch1", ch1(), 700);
      step();
      chk("R7 no queued window", int'(busy), 0);
      cal_req = 1'b0;
      step();
   endtask

   initial begin
      rst_n    = 1'b0;
      cal_req  = 1'b0;
      in_valid = 2'b00;
      in_data  = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_passthrough();
      t_calibrate_a();
      t_saturate();
      t_busy_restart();
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
   end

endmodule